// File: doc/BRIEF.md
# Recirculating Output Contention Arbiter

This block settles, once per time slot, which cell each output of a switch fabric accepts. Contenders are the cells offered on the fresh input ports plus the cells held on the recirculation ports. Each contender carries a destination output and an age-based priority. Every output grants exactly one of the cells addressed to it. The cell with the greatest priority wins, and a tie goes to the smaller contender index.

A losing cell is not queued. It is written into a recirculation port with its priority raised by one, and it contends again in the following slot. A cell drops out only in two cases: it has already reached the top priority level, or the recirculation ports are full. A cell that has waited longer therefore always beats a younger cell for the same output, which keeps cells of a connection in order. Grants and drop flags are combinational within the slot. The recirculation ports are registered, and each slot edge refills all of them.

Top module: `recirc_arbiter`

## Requirements
- R1: In each slot every output grants at most one contender. A grant names a valid contender whose destination is that output, and an output with at least one contender always grants.
- R2: Among contenders for one output, the one with the highest priority wins.
- R3: Among equal-priority contenders, the lowest contender index wins. Fresh input port i has index i, and recirculation port k has index N_IN+k.
- R4: A losing cell below the top level appears on a recirculation port in the next slot with the same destination and its priority plus one, and there it contends again.
- R5: A cell on a fresh input port contends at priority 0.
- R6: A losing cell already at the top level (all priority bits set) is discarded, and its drop bit is high in that slot.
- R7: When more eligible losers exist than recirculation ports, the losers are ranked by aged priority, with ties going to the lower index. The best-ranked loser takes port 0, the next takes port 1, and so on. The rest are discarded with their drop bits set.
- R8: After reset the recirculation ports are empty, and with no fresh cells there is no grant and no drop.
- R9: A granted cell is neither dropped nor recirculated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | slot clock |
| rst_n | input | 1 | active-low reset |
| in_valid | input | N_IN | fresh cell present, per input port |
| in_dest | input | N_IN*DW | destination output, per input port |
| gnt_valid | output | N_OUT | output accepts a cell this slot |
| gnt_src | output | N_OUT*IW | contender index granted, per output |
| drop | output | N_IN+N_RC | contender discarded this slot |
| rc_valid | output | N_RC | recirculation port holds a cell |
| rc_dest | output | N_RC*DW | destination of the recirculated cell |
| rc_pri | output | N_RC*PW | aged priority of the recirculated cell |

## Verification
In one slot the block can both age a loser into a recirculation port and discard losers for lack of room. The bench provokes this by placing two recirculated cells on one output while four fresh cells target another. It then judges that the aged recirculated loser and the lowest-indexed fresh loser are kept in rank order and that the other two are flagged. In the same way, a top-level discard and a recirculation can fall in the same slot. A second instance with one priority bit makes this reachable, and the bench checks the drop flag and the surviving aged cell.

// File: rtl/recirc_arbiter.sv
module recirc_arbiter #(
  parameter int N_IN  = 4,
  parameter int N_RC  = 2,
  parameter int N_OUT = 4,
  parameter int PW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IN-1:0]           in_valid,
  input  logic [N_IN*((N_OUT>1)?$clog2(N_OUT):1)-1:0] in_dest,
  output logic [N_OUT-1:0]          gnt_valid,
  output logic [N_OUT*$clog2(N_IN+N_RC)-1:0] gnt_src,
  output logic [N_IN+N_RC-1:0]      drop,
  output logic [N_RC-1:0]           rc_valid,
  output logic [N_RC*((N_OUT>1)?$clog2(N_OUT):1)-1:0] rc_dest,
  output logic [N_RC*PW-1:0]        rc_pri
);
  localparam int DW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int NS = N_IN + N_RC;
  localparam int IW = $clog2(NS);
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic [N_RC-1:0]   rv_q;
  logic [DW-1:0]     rd_q [N_RC];
  logic [PW-1:0]     rp_q [N_RC];

  logic [NS-1:0]     cv;
  logic [DW-1:0]     cd [NS];
  logic [PW-1:0]     cp [NS];

  logic [IW-1:0]     gsel [N_OUT];
  logic [NS-1:0]     won;
  logic [NS-1:0]     elig, keep;
  logic [IW:0]       rank [NS];

  logic [N_RC-1:0]   nv;
  logic [DW-1:0]     nd [N_RC];
  logic [PW-1:0]     np [N_RC];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign cv[i] = in_valid[i];
    assign cd[i] = in_dest[i*DW +: DW];
    assign cp[i] = '0;
  end
  for (genvar k = 0; k < N_RC; k++) begin : g_rc
    assign cv[N_IN+k] = rv_q[k];
    assign cd[N_IN+k] = rd_q[k];
    assign cp[N_IN+k] = rp_q[k];
    assign rc_valid[k] = rv_q[k];
    assign rc_dest[k*DW +: DW] = rd_q[k];
    assign rc_pri[k*PW +: PW] = rp_q[k];
  end

  always_comb begin
    won = '0;
    for (int o = 0; o < N_OUT; o++) begin
      logic          f;
      logic [PW-1:0] bp;
      logic [IW-1:0] bi;
      f  = 1'b0;
      bp = '0;
      bi = '0;
      for (int c = 0; c < NS; c++) begin
        if (cv[c] && cd[c] == DW'(o) && (!f || cp[c] > bp)) begin
          f  = 1'b1;
          bp = cp[c];
          bi = IW'(c);
        end
      end
      gnt_valid[o] = f;
      gsel[o] = bi;
      if (f) won[bi] = 1'b1;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_gs
    assign gnt_src[o*IW +: IW] = gsel[o];
  end

  for (genvar c = 0; c < NS; c++) begin : g_el
    assign elig[c] = cv[c] && !won[c] && cp[c] != PMAX;
  end

  always_comb begin
    for (int c = 0; c < NS; c++) begin
      rank[c] = '0;
      for (int d = 0; d < NS; d++) begin
        if (elig[d] && d != c && (cp[d] > cp[c] || (cp[d] == cp[c] && d < c)))
          rank[c] = rank[c] + 1'b1;
      end
      keep[c] = elig[c] && rank[c] < (IW+1)'(N_RC);
    end
  end

  assign drop = cv & ~won & ~keep;

  always_comb begin
    for (int k = 0; k < N_RC; k++) begin
      nv[k] = 1'b0;
      nd[k] = '0;
      np[k] = '0;
      for (int c = 0; c < NS; c++) begin
        if (keep[c] && rank[c] == (IW+1)'(k)) begin
          nv[k] = 1'b1;
          nd[k] = cd[c];
          np[k] = cp[c] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= '0;
      for (int k = 0; k < N_RC; k++) begin
        rd_q[k] <= '0;
        rp_q[k] <= '0;
      end
    end else begin
      rv_q <= nv;
      for (int k = 0; k < N_RC; k++) begin
        rd_q[k] <= nd[k];
        rp_q[k] <= np[k];
      end
    end
  end

  // R4: every live contender ends the slot granted, dropped or recirculated
  a_r4_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(rc_valid) ==
      $past($countones(cv) - $countones(gnt_valid) - $countones(drop)));

  for (genvar o = 0; o < N_OUT; o++) begin : g_ao
    a_r1_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[o] |-> (cv[gsel[o]] && cd[gsel[o]] == DW'(o)));
    for (genvar c = 0; c < NS; c++) begin : g_ac
      a_r2_highest: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[o] && cv[c] && cd[c] == DW'(o)) |-> cp[c] <= cp[gsel[o]]);
      a_r3_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[o] && cv[c] && cd[c] == DW'(o) && cp[c] == cp[gsel[o]])
          |-> IW'(c) >= gsel[o]);
    end
  end

  for (genvar c = 0; c < NS; c++) begin : g_ad
    a_r6_top_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (cv[c] && !won[c] && cp[c] == PMAX) |-> drop[c]);
    a_r9_win_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(drop[c] && won[c]));
  end
endmodule

// File: tb/recirc_arbiter_test.sv
module recirc_arbiter_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] in_valid = '0;
  logic [7:0] in_dest = '0;
  logic [3:0] gnt_valid, gnt_valid_t;
  logic [11:0] gnt_src, gnt_src_t;
  logic [5:0] drop, drop_t;
  logic [1:0] rc_valid, rc_valid_t;
  logic [3:0] rc_dest, rc_dest_t;
  logic [5:0] rc_pri;
  logic [1:0] rc_pri_t;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  recirc_arbiter #(.N_IN(4), .N_RC(2), .N_OUT(4), .PW(3)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .gnt_valid(gnt_valid), .gnt_src(gnt_src), .drop(drop),
    .rc_valid(rc_valid), .rc_dest(rc_dest), .rc_pri(rc_pri));

  recirc_arbiter #(.N_IN(4), .N_RC(2), .N_OUT(4), .PW(1)) uut_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .gnt_valid(gnt_valid_t), .gnt_src(gnt_src_t), .drop(drop_t),
    .rc_valid(rc_valid_t), .rc_dest(rc_dest_t), .rc_pri(rc_pri_t));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(logic [3:0] v, logic [7:0] d);
    @(negedge clk);
    in_valid = v;
    in_dest = d;
    #1;
  endtask

  task automatic flush();
    for (int i = 0; i < 12; i++) begin
      slot(4'b0000, 8'h00);
      if (rc_valid == 2'b00 && rc_valid_t == 2'b00) break;
    end
  endtask

  task automatic t_reset();
    slot(4'b0000, 8'h00);
    chk("R8 rc_valid", 32'(rc_valid), 0);
    chk("R8 gnt_valid", 32'(gnt_valid), 0);
    chk("R8 drop", 32'(drop), 0);
  endtask

  task automatic t_basic();
    slot(4'b1111, {2'd0, 2'd3, 2'd2, 2'd1});
    chk("R1 all granted", 32'(gnt_valid), 32'hf);
    chk("R1 src o0", 32'(gnt_src[2:0]), 3);
    chk("R1 src o1", 32'(gnt_src[5:3]), 0);
    chk("R1 src o3", 32'(gnt_src[11:9]), 2);
    chk("R9 no drop", 32'(drop), 0);
    slot(4'b0000, 8'h00);
    chk("R9 nothing recirculated", 32'(rc_valid), 0);
  endtask

  task automatic t_tie_and_age();
    slot(4'b0111, {2'd1, 2'd1, 2'd1, 2'd1});
    chk("R3 tie fresh", 32'(gnt_valid), 32'h2);
    chk("R3 src fresh", 32'(gnt_src[5:3]), 0);
    chk("R4 no drop", 32'(drop), 0);
    slot(4'b0000, 8'h00);
    chk("R4 rc_valid", 32'(rc_valid), 3);
    chk("R4 rc_dest", 32'(rc_dest), 32'h5);
    chk("R5 aged to 1", 32'(rc_pri), 32'o11);
    chk("R3 tie recirc", 32'(gnt_src[5:3]), 4);
    slot(4'b0001, 8'h01);
    chk("R4 rc_valid2", 32'(rc_valid), 1);
    chk("R4 aged to 2", 32'(rc_pri[2:0]), 2);
    chk("R2 older wins", 32'(gnt_src[5:3]), 4);
    slot(4'b0000, 8'h00);
    chk("R5 fresh loser aged 1", 32'(rc_pri[2:0]), 1);
    chk("R4 dest kept", 32'(rc_dest[1:0]), 1);
    chk("R4 contends again", 32'(gnt_valid), 32'h2);
  endtask

  task automatic t_overflow();
    flush();
    slot(4'b0111, 8'h00);
    chk("R1 src o0", 32'(gnt_src[2:0]), 0);
    slot(4'b1111, {2'd3, 2'd3, 2'd3, 2'd3});
    chk("R1 two outputs", 32'(gnt_valid), 32'h9);
    chk("R3 recirc tie o0", 32'(gnt_src[2:0]), 4);
    chk("R3 fresh tie o3", 32'(gnt_src[11:9]), 0);
    chk("R7 lowest dropped", 32'(drop), 32'h0c);
    slot(4'b0000, 8'h00);
    chk("R7 ports full", 32'(rc_valid), 3);
    chk("R7 port0 dest", 32'(rc_dest[1:0]), 0);
    chk("R7 port0 pri", 32'(rc_pri[2:0]), 2);
    chk("R7 port1 dest", 32'(rc_dest[3:2]), 3);
    chk("R7 port1 pri", 32'(rc_pri[5:3]), 1);
    chk("R1 both out", 32'(gnt_valid), 32'h9);
  endtask

  task automatic t_top();
    flush();
    slot(4'b0111, 8'h00);
    slot(4'b0001, 8'h00);
    chk("R6 winner", 32'(gnt_src_t[2:0]), 4);
    chk("R6 top dropped", 32'(drop_t), 32'h20);
    slot(4'b0000, 8'h00);
    chk("R6 survivor", 32'(rc_valid_t), 1);
    chk("R6 survivor pri", 32'(rc_pri_t[0]), 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_tie_and_age();
    t_overflow();
    t_top();
    flush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule